// File: doc/BRIEF.md
# G.711 Companding Engine

This block converts audio samples between a 16-bit linear form and an 8-bit code form, in two independent directions. The transmit direction takes linear samples and produces 8-bit μ-law or A-law codes. The receive direction takes 8-bit codes and expands them back to 16-bit linear samples. Each direction has its own companding enable, its own law select, and its own byte-mode bit. Byte mode truncates or widens plain 8-bit linear data with no companding. When neither companding nor byte mode is selected, the full 16-bit word passes straight through.

In every 8-bit mode the code sits in the upper byte of the 16-bit word and the lower byte is zero. Each direction accepts one sample per valid pulse and presents its result, with a one-cycle valid strobe, on the clock edge that follows. The control inputs are static configuration bits that stand in for register fields. They change only between samples.

Top module: `g711_codec_engine`

## Requirements
- R1: After reset, txWordOut, txWordValid, rxLinOut and rxLinValid are all 0.
- R2: With txCompEn=1 and txCompAlaw=0 (μ-law), the sample is taken as the 14-bit signed value txLinIn[15:2]. The magnitude plus 33 is clamped to 8191. The segment is the leading-one position minus 5 (bits 12..5), the mantissa is the next four bits below the leading one, and bit 7 before inversion is 1 for negative. All 8 code bits are then inverted. For example, 0x0000 gives 0xFF, 0x7FFF gives 0x80, 0x8000 gives 0x00, 0xFFFC gives 0x7E, and 1000 gives 0xCE.
- R3: With txCompEn=1 and txCompAlaw=1 (A-law), the sample is the 13-bit signed value txLinIn[15:3], and the magnitude is the value, or its one's complement when negative (12 bits). Below 32 the segment is 0 and the mantissa is magnitude bits 4:1. Otherwise the segment is the leading-one position minus 4, and the mantissa is the magnitude shifted right by the segment. Bit 7 before inversion is 1 for non-negative, and the code is then XORed with 0x55. For example, 0x0000 gives 0xD5, 0x7FFF gives 0xAA, 0x8000 gives 0x2A, 0xFFF8 gives 0x55, 248 gives 0xDA, 256 gives 0xC5, and 1000 gives 0xFA.
- R4: With rxCompEn=1 and rxCompAlaw=0, the code rxWordIn[15:8] is inverted. It then expands to the interval midpoint ((2·mantissa+33)<<segment)−33, scaled by 4, and is negated when bit 7 of the inverted code is 1. For example, 0xFF gives 0, 0x80 gives 32124, 0x00 gives −32124, 0xCE gives 988, and 0x7E gives −8.
- R5: With rxCompEn=1 and rxCompAlaw=1, the code is XORed with 0x55. It then expands to the interval midpoint scaled by 8, and is negative when bit 7 is 0. For example, 0xD5 gives 8, 0xAA gives 32256, 0x2A gives −32256, 0xFA gives 1008, 0x55 gives −8, and 0xC5 gives 264.
- R6: With the direction's enable at 0 and its byte-mode bit at 1, the upper byte passes through unchanged and the lower byte of the result is 0. For example, tx 0xA5C3 gives 0xA500 and rx 0x3C77 gives 0x3C00.
- R7: With enable at 0 and byte-mode at 0, the full 16-bit word passes through unchanged. With enable at 1, the byte-mode bit has no effect.
- R8: A valid input pulse produces a result and a single-cycle output valid on the next rising clock edge. With no valid input, the output data holds its value and the output valid stays 0.
- R9: The transmit code occupies bits 15:8 of txWordOut, with bits 7:0 at 0. The receive side ignores rxWordIn[7:0] in both companding modes.
- R10: The two directions are configured and operate independently, and can run on different laws in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txCompEn | input | 1 | Transmit companding enable |
| txCompAlaw | input | 1 | Transmit law: 0 μ-law, 1 A-law |
| txByteMode | input | 1 | Transmit plain 8-bit mode when companding is off |
| rxCompEn | input | 1 | Receive companding enable |
| rxCompAlaw | input | 1 | Receive law: 0 μ-law, 1 A-law |
| rxByteMode | input | 1 | Receive plain 8-bit mode when companding is off |
| txLinIn | input | 16 | Linear sample to transmit |
| txLinValid | input | 1 | Transmit sample strobe |
| txWordOut | output | 16 | Transmit word, with the code in bits 15:8 in 8-bit modes |
| txWordValid | output | 1 | Transmit result strobe |
| rxWordIn | input | 16 | Received word, with the code in bits 15:8 |
| rxWordValid | input | 1 | Receive word strobe |
| rxLinOut | output | 16 | Expanded linear sample |
| rxLinValid | output | 1 | Receive result strobe |

## Verification
Each result register is loaded only on a valid strobe. A wrong segment search, a wrong bias or a wrong inversion mask therefore shows up on the very next output word, one clock after the sample that triggers it. Boundary samples are chosen to expose faults in specific places. Full-scale samples of both signs reveal a missing clamp or a missing saturation. Magnitudes 31 and 32 straddle the A-law linear segment. The values −1 and 0 separate the one's-complement form of the sign handling from the two's-complement form. A strobe that is generated wrongly appears in the same cycle as a missing or repeated valid, or as output data that changes while no input is offered.

// File: rtl/companding_pkg.sv
package companding_pkg;

  localparam int LIN_W  = 16;
  localparam int CODE_W = 8;
  localparam int PAD_W  = LIN_W - CODE_W;
  localparam int MU_W   = 14;   // sign + 13-bit magnitude
  localparam int AL_W   = 13;   // sign + 12-bit magnitude
  localparam int MU_BIAS = 33;
  localparam int MU_CLIP = (1 << (MU_W - 1)) - 1;
  localparam logic [CODE_W-1:0] MU_FLIP = 8'hFF;
  localparam logic [CODE_W-1:0] AL_FLIP = 8'h55;

  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_BYTE   = 2'd1,
    MODE_MULAW  = 2'd2,
    MODE_ALAW   = 2'd3
  } pathMode_t;

  typedef struct packed {
    logic      txLoad;
    logic      rxLoad;
    pathMode_t txMode;
    pathMode_t rxMode;
  } ctrlStrobes_t;

  function automatic logic [CODE_W-1:0] muEncode(input logic [LIN_W-1:0] lin);
    logic [MU_W-1:0] smp;
    logic            neg;
    logic [MU_W:0]   absV;
    logic [LIN_W-1:0] biased;
    logic [MU_W-2:0] mag;
    logic [2:0]      seg;
    logic [3:0]      mant;
    smp    = lin[LIN_W-1 -: MU_W];
    neg    = smp[MU_W-1];
    absV   = neg ? ((MU_W+1)'(0) - {1'b1, smp}) : {1'b0, smp};
    biased = LIN_W'(absV) + LIN_W'(MU_BIAS);
    mag    = (biased > LIN_W'(MU_CLIP)) ? (MU_W-1)'(MU_CLIP) : biased[MU_W-2:0];
    seg    = 3'd0;
    for (int b = 5; b < MU_W - 1; b++) begin
      if (mag[b]) seg = 3'(b - 5);
    end
    mant = 4'(mag >> ({1'b0, seg} + 4'd1));
    return {neg, seg, mant} ^ MU_FLIP;
  endfunction

  function automatic logic [CODE_W-1:0] alEncode(input logic [LIN_W-1:0] lin);
    logic [AL_W-1:0] smp;
    logic            neg;
    logic [AL_W-2:0] mag;
    logic [2:0]      seg;
    logic [3:0]      mant;
    smp = lin[LIN_W-1 -: AL_W];
    neg = smp[AL_W-1];
    mag = neg ? ~smp[AL_W-2:0] : smp[AL_W-2:0];
    seg = 3'd0;
    for (int b = 5; b < AL_W - 1; b++) begin
      if (mag[b]) seg = 3'(b - 4);
    end
    mant = (seg == 3'd0) ? mag[4:1] : 4'(mag >> seg);
    return {~neg, seg, mant} ^ AL_FLIP;
  endfunction

  function automatic logic [LIN_W-1:0] muDecode(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] u;
    logic [LIN_W-1:0]  t;
    u = code ^ MU_FLIP;
    t = ({9'd0, u[3:0], 3'b000} + 16'd132) << u[6:4];
    return u[7] ? (16'd132 - t) : (t - 16'd132);
  endfunction

  function automatic logic [LIN_W-1:0] alDecode(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] a;
    logic [LIN_W-1:0]  t;
    a = code ^ AL_FLIP;
    t = {8'd0, a[3:0], 4'b0000} + ((a[6:4] == 3'd0) ? 16'd8 : 16'd264);
    if (a[6:4] > 3'd1) t = t << (a[6:4] - 3'd1);
    return a[7] ? t : (16'd0 - t);
  endfunction

endpackage

// File: rtl/compand_ctrl.sv
module compand_ctrl
  import companding_pkg::*;
(
  input  logic         txCompEn,
  input  logic         txCompAlaw,
  input  logic         txByteMode,
  input  logic         rxCompEn,
  input  logic         rxCompAlaw,
  input  logic         rxByteMode,
  input  logic         txLinValid,
  input  logic         rxWordValid,
  output ctrlStrobes_t strobes
);

  function automatic pathMode_t pickMode(input logic en, input logic alaw, input logic byteMode);
    if (en)       return alaw ? MODE_ALAW : MODE_MULAW;
    if (byteMode) return MODE_BYTE;
    return MODE_LINEAR;
  endfunction

  always_comb begin
    strobes.txLoad = txLinValid;
    strobes.rxLoad = rxWordValid;
    strobes.txMode = pickMode(txCompEn, txCompAlaw, txByteMode);
    strobes.rxMode = pickMode(rxCompEn, rxCompAlaw, rxByteMode);
  end

endmodule

// File: rtl/compand_datapath.sv
module compand_datapath
  import companding_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [LIN_W-1:0] txLinIn,
  input  logic [LIN_W-1:0] rxWordIn,
  output logic [LIN_W-1:0] txWordOut,
  output logic             txWordValid,
  output logic [LIN_W-1:0] rxLinOut,
  output logic             rxLinValid
);

  logic [LIN_W-1:0] txNext;
  logic [LIN_W-1:0] rxNext;

  always_comb begin
    unique case (strobes.txMode)
      MODE_MULAW: txNext = {muEncode(txLinIn), PAD_W'(0)};
      MODE_ALAW:  txNext = {alEncode(txLinIn), PAD_W'(0)};
      MODE_BYTE:  txNext = {txLinIn[LIN_W-1 -: CODE_W], PAD_W'(0)};
      default:    txNext = txLinIn;
    endcase
  end

  always_comb begin
    unique case (strobes.rxMode)
      MODE_MULAW: rxNext = muDecode(rxWordIn[LIN_W-1 -: CODE_W]);
      MODE_ALAW:  rxNext = alDecode(rxWordIn[LIN_W-1 -: CODE_W]);
      MODE_BYTE:  rxNext = {rxWordIn[LIN_W-1 -: CODE_W], PAD_W'(0)};
      default:    rxNext = rxWordIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWordOut   <= '0;
      txWordValid <= 1'b0;
      rxLinOut    <= '0;
      rxLinValid  <= 1'b0;
    end else begin
      txWordValid <= strobes.txLoad;
      rxLinValid  <= strobes.rxLoad;
      if (strobes.txLoad) txWordOut <= txNext;
      if (strobes.rxLoad) rxLinOut  <= rxNext;
    end
  end

  // R8: result strobe one cycle after each load, never otherwise
  a_r8_tx_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txLoad |=> txWordValid);
  a_r8_tx_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.txLoad |=> !txWordValid);
  a_r8_rx_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxLoad |=> rxLinValid);
  a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rxLoad |=> $stable(rxLinOut));
  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.txLoad |=> $stable(txWordOut));
  // R9: 8-bit results leave the low byte clear
  a_r9_tx_low_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txLoad && strobes.txMode != MODE_LINEAR) |=> (txWordOut[PAD_W-1:0] == '0));
  // R6: receive byte mode clears the low byte
  a_r6_rx_byte_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rxLoad && strobes.rxMode == MODE_BYTE) |=> (rxLinOut[PAD_W-1:0] == '0));

endmodule

// File: rtl/g711_codec_engine.sv
module g711_codec_engine
  import companding_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             txCompEn,
  input  logic             txCompAlaw,
  input  logic             txByteMode,
  input  logic             rxCompEn,
  input  logic             rxCompAlaw,
  input  logic             rxByteMode,
  input  logic [LIN_W-1:0] txLinIn,
  input  logic             txLinValid,
  output logic [LIN_W-1:0] txWordOut,
  output logic             txWordValid,
  input  logic [LIN_W-1:0] rxWordIn,
  input  logic             rxWordValid,
  output logic [LIN_W-1:0] rxLinOut,
  output logic             rxLinValid
);

  ctrlStrobes_t strobes;

  compand_ctrl uCtrl (
    .txCompEn   (txCompEn),
    .txCompAlaw (txCompAlaw),
    .txByteMode (txByteMode),
    .rxCompEn   (rxCompEn),
    .rxCompAlaw (rxCompAlaw),
    .rxByteMode (rxByteMode),
    .txLinValid (txLinValid),
    .rxWordValid(rxWordValid),
    .strobes    (strobes)
  );

  compand_datapath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .txLinIn    (txLinIn),
    .rxWordIn   (rxWordIn),
    .txWordOut  (txWordOut),
    .txWordValid(txWordValid),
    .rxLinOut   (rxLinOut),
    .rxLinValid (rxLinValid)
  );

endmodule

// File: tb/tb_g711_codec_engine.sv
`timescale 1ns/1ps
module tb_g711_codec_engine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txCompEn = 0, txCompAlaw = 0, txByteMode = 0;
  logic rxCompEn = 0, rxCompAlaw = 0, rxByteMode = 0;
  logic [15:0] txLinIn = '0;
  logic        txLinValid = 0;
  logic [15:0] rxWordIn = '0;
  logic        rxWordValid = 0;
  logic [15:0] txWordOut, rxLinOut;
  logic        txWordValid, rxLinValid;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  g711_codec_engine dut (
    .clk(clk), .rstN(rstN),
    .txCompEn(txCompEn), .txCompAlaw(txCompAlaw), .txByteMode(txByteMode),
    .rxCompEn(rxCompEn), .rxCompAlaw(rxCompAlaw), .rxByteMode(rxByteMode),
    .txLinIn(txLinIn), .txLinValid(txLinValid),
    .txWordOut(txWordOut), .txWordValid(txWordValid),
    .rxWordIn(rxWordIn), .rxWordValid(rxWordValid),
    .rxLinOut(rxLinOut), .rxLinValid(rxLinValid)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendTx(input logic [15:0] lin, input logic [15:0] exp, input string req);
    @(negedge clk);
    txLinIn = lin; txLinValid = 1;
    @(negedge clk);
    txLinValid = 0;
    check(txWordValid === 1'b1, {req, " tx valid"}, {15'd0, txWordValid}, 16'd1);
    check(txWordOut === exp, req, txWordOut, exp);
  endtask

  task automatic sendRx(input logic [15:0] word, input logic [15:0] exp, input string req);
    @(negedge clk);
    rxWordIn = word; rxWordValid = 1;
    @(negedge clk);
    rxWordValid = 0;
    check(rxLinValid === 1'b1, {req, " rx valid"}, {15'd0, rxLinValid}, 16'd1);
    check(rxLinOut === exp, req, rxLinOut, exp);
  endtask

  task automatic testReset;
    check(txWordOut === 16'h0, "R1 txWordOut", txWordOut, 16'h0);
    check(txWordValid === 1'b0, "R1 txWordValid", {15'd0, txWordValid}, 16'h0);
    check(rxLinOut === 16'h0, "R1 rxLinOut", rxLinOut, 16'h0);
    check(rxLinValid === 1'b0, "R1 rxLinValid", {15'd0, rxLinValid}, 16'h0);
  endtask

  task automatic testMuEncode;
    txCompEn = 1; txCompAlaw = 0; txByteMode = 0;
    sendTx(16'h0000, 16'hFF00, "R2 zero");
    sendTx(16'h7FFF, 16'h8000, "R2 pos full");
    sendTx(16'h8000, 16'h0000, "R2 neg full");
    sendTx(16'hFFFC, 16'h7E00, "R2 minus one");
    sendTx(16'd1000, 16'hCE00, "R2 mid");
  endtask

  task automatic testAEncode;
    txCompEn = 1; txCompAlaw = 1;
    sendTx(16'h0000, 16'hD500, "R3 zero");
    sendTx(16'h7FFF, 16'hAA00, "R3 pos full");
    sendTx(16'h8000, 16'h2A00, "R3 neg full");
    sendTx(16'hFFF8, 16'h5500, "R3 minus one");
    sendTx(16'd248,  16'hDA00, "R3 seg0 top");
    sendTx(16'd256,  16'hC500, "R3 seg1 base");
    sendTx(16'd1000, 16'hFA00, "R3 mid");
  endtask

  task automatic testMuDecode;
    rxCompEn = 1; rxCompAlaw = 0; rxByteMode = 0;
    sendRx(16'hFF00, 16'h0000, "R4 zero");
    sendRx(16'h8000, 16'h7D7C, "R4 pos full");
    sendRx(16'h0000, 16'h8284, "R4 neg full");
    sendRx(16'hCE00, 16'h03DC, "R4 mid");
    sendRx(16'h7E00, 16'hFFF8, "R4 minus");
  endtask

  task automatic testADecode;
    rxCompEn = 1; rxCompAlaw = 1;
    sendRx(16'hD500, 16'h0008, "R5 zero");
    sendRx(16'hAA00, 16'h7E00, "R5 pos full");
    sendRx(16'h2A00, 16'h8200, "R5 neg full");
    sendRx(16'hFA00, 16'h03F0, "R5 mid");
    sendRx(16'h5500, 16'hFFF8, "R5 minus");
    sendRx(16'hC500, 16'h0108, "R5 seg1 base");
  endtask

  task automatic testByteMode;
    txCompEn = 0; txByteMode = 1;
    rxCompEn = 0; rxByteMode = 1;
    sendTx(16'hA5C3, 16'hA500, "R6 tx byte");
    sendRx(16'h3C77, 16'h3C00, "R6 rx byte");
  endtask

  task automatic testPassThrough;
    txCompEn = 0; txByteMode = 0;
    rxCompEn = 0; rxByteMode = 0;
    sendTx(16'hA5C3, 16'hA5C3, "R7 tx linear");
    sendRx(16'h3C77, 16'h3C77, "R7 rx linear");
    txCompEn = 1; txCompAlaw = 0; txByteMode = 1;
    rxCompEn = 1; rxCompAlaw = 1; rxByteMode = 1;
    sendTx(16'h0000, 16'hFF00, "R7 tx enable over byte");
    sendRx(16'hD500, 16'h0008, "R7 rx enable over byte");
  endtask

  task automatic testHold;
    logic [15:0] heldTx, heldRx;
    txCompEn = 1; txCompAlaw = 0; txByteMode = 0;
    sendTx(16'd1000, 16'hCE00, "R8 load");
    heldTx = txWordOut; heldRx = rxLinOut;
    txLinIn = 16'h1234; rxWordIn = 16'h5678;
    repeat (3) @(negedge clk);
    check(txWordValid === 1'b0, "R8 tx strobe single", {15'd0, txWordValid}, 16'd0);
    check(rxLinValid === 1'b0, "R8 rx strobe idle", {15'd0, rxLinValid}, 16'd0);
    check(txWordOut === heldTx, "R8 tx hold", txWordOut, heldTx);
    check(rxLinOut === heldRx, "R8 rx hold", rxLinOut, heldRx);
  endtask

  task automatic testLowByte;
    txCompEn = 1; txCompAlaw = 1;
    sendTx(16'h7FFF, 16'hAA00, "R9 tx low byte clear");
    rxCompEn = 1; rxCompAlaw = 0;
    sendRx(16'hCE55, 16'h03DC, "R9 rx mu low ignored");
    rxCompAlaw = 1;
    sendRx(16'hFAFF, 16'h03F0, "R9 rx A low ignored");
  endtask

  task automatic testIndependent;
    txCompEn = 1; txCompAlaw = 1; txByteMode = 0;
    rxCompEn = 1; rxCompAlaw = 0; rxByteMode = 0;
    @(negedge clk);
    txLinIn = 16'd1000; txLinValid = 1;
    rxWordIn = 16'h8000; rxWordValid = 1;
    @(negedge clk);
    txLinValid = 0; rxWordValid = 0;
    check(txWordOut === 16'hFA00, "R10 tx A-law", txWordOut, 16'hFA00);
    check(rxLinOut === 16'h7D7C, "R10 rx mu-law", rxLinOut, 16'h7D7C);
  endtask

  task automatic finishRun;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testMuEncode();
    testAEncode();
    testMuDecode();
    testADecode();
    testByteMode();
    testPassThrough();
    testHold();
    testLowByte();
    testIndependent();
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule